// File: doc/BRIEF.md
# Dual-Bus Banked Local Memory Arbiter

This block sits between two independent request buses and a small local memory split into interleaved banks. The fetch bus only reads. The data bus reads and writes. Each bus has a valid/ready request handshake and its own registered response path. The low-order bits of the word address pick the bank, so that consecutive words fall in different banks. Requests to different banks are accepted in the same cycle and do not affect each other.

An accepted access occupies its bank for a fixed number of cycles and is never cut short. A request that reaches a bank which is busy, or that loses a same-cycle contest for a bank, is stretched: its ready signal stays low until the bank can take it. Each bus therefore runs at whatever rate its own traffic allows. When two requests compete for a bank that has just become free, a request that was already waiting goes before one that has just arrived. If neither or both were waiting, the data bus goes first.

Top module: `dual_bus_bank_arbiter`

## Requirements
- R1: A word address maps to bank `addr[BANK_BITS-1:0]` (bank 0..3 with the defaults) and to row `addr[ADDR_W-1:BANK_BITS]`. A read on either bus returns the value last written to that word by the data bus.
- R2: An accepted access holds its bank for ACCESS_CYC cycles (3 by default), counting the accept cycle. Neither bus is accepted at that bank until the window ends.
- R3: When both buses present requests to two different banks that are both free, both requests are accepted in the same cycle.
- R4: When both buses present requests to the same free bank, and either neither or both of them were waiting in the previous cycle, the data bus is accepted and the fetch bus is stalled.
- R5: When one bus was waiting in the previous cycle and the other bus arrives fresh at the same bank as that bank becomes free, the waiting bus is accepted and the fresh one is stalled.
- R6: A bus's ready is high exactly in the cycles its request is accepted: valid is high, the bank is free and the contest is not lost. Ready is low in every other cycle, including cycles where valid is low.
- R7: Each accepted read raises that bus's response valid in the following cycle, with the read data. An accepted write on the data bus raises no response.
- R8: While reset is asserted, both ready outputs and both response valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| iValid | input | 1 | Fetch bus request valid |
| iAddr | input | ADDR_W | Fetch bus word address |
| iReady | output | 1 | Fetch bus request accepted this cycle |
| iRspValid | output | 1 | Fetch read data valid |
| iRspData | output | DATA_W | Fetch read data |
| dValid | input | 1 | Data bus request valid |
| dWrite | input | 1 | Data bus request is a write |
| dAddr | input | ADDR_W | Data bus word address |
| dWdata | input | DATA_W | Data bus write data |
| dReady | output | 1 | Data bus request accepted this cycle |
| dRspValid | output | 1 | Data bus read data valid |
| dRspData | output | DATA_W | Data bus read data |

## Verification
The hardest case to reach is the order-of-arrival rule. The fetch bus must already be stalled on a bank, and the data bus must then arrive at that same bank in exactly the cycle its busy window ends. Random traffic rarely lines this up. A directed sequence therefore forces a same-bank tie, holds the losing fetch request, and raises a fresh data request precisely ACCESS_CYC cycles later. Random traffic biased towards one bank then mixes ties, waits and parallel accesses, and each cycle is compared against a bench model.

// File: rtl/dbb_pkg.sv
package dbb_pkg;
  typedef struct packed {
    logic iTake;   // fetch request accepted this cycle
    logic dTake;   // data request accepted this cycle
    logic dStore;  // accepted data request is a write
  } dbbStrobe_t;
endpackage

// File: rtl/dbb_ctrl.sv
module dbb_ctrl
  import dbb_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int BANK_BITS  = 2,
  parameter int ACCESS_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              iValid,
  input  logic [ADDR_W-1:0] iAddr,
  input  logic              dValid,
  input  logic              dWrite,
  input  logic [ADDR_W-1:0] dAddr,
  output dbbStrobe_t        strobe
);
  localparam int NBANK = 1 << BANK_BITS;
  localparam int CNT_W = (ACCESS_CYC > 2) ? $clog2(ACCESS_CYC) : 1;
  localparam logic [CNT_W-1:0] HOLD = CNT_W'(ACCESS_CYC - 1);

  logic [BANK_BITS-1:0] iBank, dBank;
  logic [CNT_W-1:0]     busyCnt [NBANK];
  logic [NBANK-1:0]     bankFree;
  logic                 iWaitQ, dWaitQ;
  logic                 iFree, dFree, contest, fetchFirst;
  logic                 iTake, dTake;

  assign iBank = iAddr[BANK_BITS-1:0];
  assign dBank = dAddr[BANK_BITS-1:0];

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign bankFree[b] = (busyCnt[b] == '0);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          busyCnt[b] <= '0;
        else if ((iTake && iBank == BANK_BITS'(b)) || (dTake && dBank == BANK_BITS'(b)))
          busyCnt[b] <= HOLD;
        else if (busyCnt[b] != '0)
          busyCnt[b] <= busyCnt[b] - 1'b1;
      end
    end
  endgenerate

  assign iFree      = bankFree[iBank];
  assign dFree      = bankFree[dBank];
  assign contest    = iValid && dValid && (iBank == dBank) && iFree;
  assign fetchFirst = iWaitQ && !dWaitQ;

  always_comb begin
    dTake = rstN && dValid && dFree && !(contest && fetchFirst);
    iTake = rstN && iValid && iFree && !(contest && !fetchFirst);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iWaitQ <= 1'b0;
      dWaitQ <= 1'b0;
    end else begin
      iWaitQ <= iValid && !iTake;
      dWaitQ <= dValid && !dTake;
    end
  end

  assign strobe.iTake  = iTake;
  assign strobe.dTake  = dTake;
  assign strobe.dStore = dTake && dWrite;

  // R4: one owner per bank in any cycle
  a_r4_single_owner: assert property (@(posedge clk) disable iff (!rstN)
    (iTake && dTake) |-> (iBank != dBank));

  // R2: an access in progress is never pre-empted
  a_r2_no_preempt_i: assert property (@(posedge clk) disable iff (!rstN)
    iTake |=> !(iTake && iBank == $past(iBank)) && !(dTake && dBank == $past(iBank)));
  a_r2_no_preempt_d: assert property (@(posedge clk) disable iff (!rstN)
    dTake |=> !(iTake && iBank == $past(dBank)) && !(dTake && dBank == $past(dBank)));

  // R3: disjoint free banks proceed together
  a_r3_parallel: assert property (@(posedge clk) disable iff (!rstN)
    (iValid && dValid && iBank != dBank && iFree && dFree) |-> (iTake && dTake));

  // R6: acceptance only with a valid request
  a_r6_take_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    (iTake |-> iValid) and (dTake |-> dValid));
endmodule

// File: rtl/dbb_datapath.sv
module dbb_datapath
  import dbb_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BANK_BITS = 2,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dbbStrobe_t        strobe,
  input  logic [ADDR_W-1:0] iAddr,
  input  logic [ADDR_W-1:0] dAddr,
  input  logic [DATA_W-1:0] dWdata,
  output logic              iRspValid,
  output logic [DATA_W-1:0] iRspData,
  output logic              dRspValid,
  output logic [DATA_W-1:0] dRspData
);
  localparam int NBANK = 1 << BANK_BITS;
  localparam int ROW_W = ADDR_W - BANK_BITS;
  localparam int ROWS  = 1 << ROW_W;

  logic [BANK_BITS-1:0] iBank, dBank;
  logic [ROW_W-1:0]     iRow, dRow;
  logic [DATA_W-1:0]    rdI [NBANK];
  logic [DATA_W-1:0]    rdD [NBANK];

  assign iBank = iAddr[BANK_BITS-1:0];
  assign dBank = dAddr[BANK_BITS-1:0];
  assign iRow  = iAddr[ADDR_W-1:BANK_BITS];
  assign dRow  = dAddr[ADDR_W-1:BANK_BITS];

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_mem
      logic [DATA_W-1:0] cells [ROWS];
      always_ff @(posedge clk) begin
        if (strobe.dStore && dBank == BANK_BITS'(b))
          cells[dRow] <= dWdata;
      end
      assign rdI[b] = cells[iRow];
      assign rdD[b] = cells[dRow];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iRspValid <= 1'b0;
      dRspValid <= 1'b0;
    end else begin
      iRspValid <= strobe.iTake;
      dRspValid <= strobe.dTake && !strobe.dStore;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.iTake)                    iRspData <= rdI[iBank];
    if (strobe.dTake && !strobe.dStore)  dRspData <= rdD[dBank];
  end

  // R7: a read acceptance always yields a response next cycle
  a_r7_fetch_rsp: assert property (@(posedge clk) disable iff (!rstN)
    strobe.iTake |=> iRspValid);
  // R7: a write acceptance never yields a data response
  a_r7_no_write_rsp: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dStore |=> !dRspValid);
endmodule

// File: rtl/dual_bus_bank_arbiter.sv
module dual_bus_bank_arbiter
  import dbb_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int BANK_BITS  = 2,
  parameter int DATA_W     = 16,
  parameter int ACCESS_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              iValid,
  input  logic [ADDR_W-1:0] iAddr,
  output logic              iReady,
  output logic              iRspValid,
  output logic [DATA_W-1:0] iRspData,
  input  logic              dValid,
  input  logic              dWrite,
  input  logic [ADDR_W-1:0] dAddr,
  input  logic [DATA_W-1:0] dWdata,
  output logic              dReady,
  output logic              dRspValid,
  output logic [DATA_W-1:0] dRspData
);
  dbbStrobe_t strobe;

  dbb_ctrl #(.ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS), .ACCESS_CYC(ACCESS_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .iValid(iValid), .iAddr(iAddr),
    .dValid(dValid), .dWrite(dWrite), .dAddr(dAddr), .strobe(strobe)
  );

  dbb_datapath #(.ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .iAddr(iAddr), .dAddr(dAddr),
    .dWdata(dWdata), .iRspValid(iRspValid), .iRspData(iRspData),
    .dRspValid(dRspValid), .dRspData(dRspData)
  );

  assign iReady = strobe.iTake;
  assign dReady = strobe.dTake;

  // R8: nothing is accepted while reset is held
  a_r8_reset_quiet: assert property (@(posedge clk) !rstN |-> (!iReady && !dReady));
endmodule

// File: tb/dual_bus_bank_arbiter_test.sv
`timescale 1ns/1ps
module dual_bus_bank_arbiter_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        iValid = 1'b0, dValid = 1'b0, dWrite = 1'b0;
  logic [5:0]  iAddr = '0, dAddr = '0;
  logic [15:0] dWdata = '0;
  logic        iReady, iRspValid, dReady, dRspValid;
  logic [15:0] iRspData, dRspData;

  int tests = 0, fails = 0;
  int mcnt [4];
  bit iw = 0, dw = 0, iAcc = 0, dAcc = 0;
  logic [15:0] shadow [64];
  bit expIV = 0, expDV = 0;
  logic [15:0] expID = '0, expDD = '0;

  always #2.5 clk = ~clk;

  dual_bus_bank_arbiter uut (
    .clk(clk), .rstN(rstN), .iValid(iValid), .iAddr(iAddr), .iReady(iReady),
    .iRspValid(iRspValid), .iRspData(iRspData), .dValid(dValid), .dWrite(dWrite),
    .dAddr(dAddr), .dWdata(dWdata), .dReady(dReady), .dRspValid(dRspValid),
    .dRspData(dRspData)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // called just after a falling edge with inputs already set
  task automatic doCycle();
    logic [1:0] iB, dB;
    bit eI, eD;
    string tag;
    #1;
    iB = iAddr[1:0];
    dB = dAddr[1:0];
    eI = iValid && (mcnt[iB] == 0);
    eD = dValid && (mcnt[dB] == 0);
    tag = "R6";
    if (iValid && dValid && iB != dB) tag = "R3";
    if (eI && eD && iB == dB) begin
      if (iw != dw) tag = "R5"; else tag = "R4";
      if (iw && !dw) eD = 0; else eI = 0;
    end
    if ((iValid && mcnt[iB] != 0) || (dValid && mcnt[dB] != 0)) tag = "R2";
    chk(tag, "iReady", iReady, eI);
    chk(tag, "dReady", dReady, eD);
    chk("R7", "iRspValid", iRspValid, expIV);
    if (expIV) chk("R1", "iRspData", iRspData, expID);
    chk("R7", "dRspValid", dRspValid, expDV);
    if (expDV) chk("R1", "dRspData", dRspData, expDD);
    @(posedge clk);
    expIV = eI;
    expID = shadow[iAddr];
    expDV = eD && !dWrite;
    expDD = shadow[dAddr];
    if (eD && dWrite) shadow[dAddr] = dWdata;
    for (int b = 0; b < 4; b++) if (mcnt[b] > 0) mcnt[b]--;
    if (eI) mcnt[iB] = 2;
    if (eD) mcnt[dB] = 2;
    iw = iValid && !eI;
    dw = dValid && !eD;
    iAcc = eI;
    dAcc = eD;
    @(negedge clk);
  endtask

  function automatic logic [5:0] pickAddr();
    logic [1:0] bk;
    bk = ($urandom % 2 == 0) ? 2'd1 : 2'($urandom % 4);
    return {4'($urandom % 16), bk};
  endfunction

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int b = 0; b < 4; b++) mcnt[b] = 0;
    for (int a = 0; a < 64; a++) shadow[a] = '0;
    iValid = 1; dValid = 1; iAddr = 6'd1; dAddr = 6'd1;
    repeat (3) @(negedge clk);
    // R8: reset holds everything quiet
    chk("R8", "iReady", iReady, 0);
    chk("R8", "dReady", dReady, 0);
    chk("R8", "iRspValid", iRspValid, 0);
    chk("R8", "dRspValid", dRspValid, 0);
    iValid = 0; dValid = 0;
    rstN = 1;
    @(negedge clk);

    // R6: idle bus stays not-ready
    repeat (2) doCycle();

    // fill memory through the data bus (R1)
    for (int a = 0; a < 64; a++) begin
      dValid = 1; dWrite = 1; dAddr = 6'(a); dWdata = 16'(a * 37 + 5);
      doCycle();
      while (!dAcc) doCycle();
    end
    dValid = 0; dWrite = 0;
    repeat (4) doCycle();

    // R3: different banks together
    iValid = 1; iAddr = 6'd2; dValid = 1; dAddr = 6'd7;
    doCycle();
    chk("R3", "both accepted", {30'd0, iAcc, dAcc}, 32'd3);
    iValid = 0; dValid = 0;
    repeat (3) doCycle();

    // R4 then R5: tie, fetch waits, fresh data arrives as bank frees
    iValid = 1; iAddr = 6'd5; dValid = 1; dAddr = 6'd9;
    doCycle();
    chk("R4", "data wins tie", {30'd0, iAcc, dAcc}, 32'd1);
    dValid = 0;
    doCycle();
    doCycle();
    chk("R2", "fetch still held", iAcc, 0);
    dValid = 1; dAddr = 6'd13;
    doCycle();
    chk("R5", "waiting fetch wins", {30'd0, iAcc, dAcc}, 32'd2);
    iValid = 0;
    for (int k = 0; k < 6 && !dAcc; k++) doCycle();
    chk("R2", "data served after window", dAcc, 1);
    dValid = 0;
    repeat (3) doCycle();

    // random mix
    for (int n = 0; n < 3000; n++) begin
      if (!iValid || iAcc) begin
        iValid = ($urandom % 4) != 0;
        iAddr = pickAddr();
      end
      if (!dValid || dAcc) begin
        dValid = ($urandom % 4) != 0;
        dAddr = pickAddr();
        dWrite = ($urandom % 3) == 0;
        dWdata = 16'($urandom);
      end
      iAcc = 0; dAcc = 0;
      doCycle();
    end
    iValid = 0; dValid = 0;
    repeat (3) doCycle();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule